// File: doc/BRIEF.md
# Custom-Format Pipelined Floating-Point Adder

This block adds, or subtracts, two numbers held in a compact floating-point format. The format has a sign bit, an exponent of `WEXP` bits and a significand of `WMAN` bits of precision, where the leading one is implied. Exponent widths and significand widths can be chosen to suit the multiplier tiles of the target fabric. The format has no NaN and no subnormals. An exponent field of zero always means zero. An all-ones exponent always means infinity. Results that fall below the normal range are either flushed to +0 or lifted to the smallest normal value, depending on how far below the range they fall.

The datapath runs through five stages: decode and swap, exponent alignment, the add itself, normalisation, and rounding with packing. The register after decode, after alignment, after normalisation, after packing and at the output can each be switched on or off by its own parameter. Latency therefore runs from zero cycles (purely combinational) to five cycles. The flow carries no back-pressure. An input valid travels alongside the data, and the output valid is that same flag delayed by the number of enabled registers.

An error flag marks results that could not be represented faithfully: a finite sum that overflowed to infinity, or the clash of two opposite infinities.

Top module: `cfp_adder`

## Requirements
- R1: A word is laid out as sign in the top bit, then `WEXP` exponent bits, then `WMAN-1` fraction bits in the low bits. A normal value equals (1.fraction) × 2^(exponent − (2^(WEXP−1)−1)). An input whose exponent field is zero counts as zero, whatever its fraction bits hold.
- R2: The sum of two finite operands is rounded to the nearest representable value, with ties going to the value whose fraction LSB is zero.
- R3: With `i_sub` high, the result is `i_a` minus `i_b`, formed by flipping the sign of `i_b` before the add. Every other rule applies unchanged.
- R4: A zero result is always encoded as all-zero bits (+0), including x + (−x) and sums of negative zeros. Negative zero is never produced.
- R5: When the exact finite result has magnitude below half the smallest normal value, the output is +0. When it lies in [half the smallest normal, smallest normal), the output is the smallest normal value (exponent field 1, fraction 0) carrying the result's sign.
- R6: A finite sum whose rounded exponent reaches the all-ones code becomes an infinity with the result's sign, and `o_err` is high.
- R7: Adding +∞ to −∞ (after any subtraction sign flip) gives +0 with `o_err` high.
- R8: Infinity is encoded as an all-ones exponent with a zero fraction. Any input with an all-ones exponent is taken as infinity regardless of its fraction bits. An infinity plus a finite value, or plus an infinity of the same sign, returns that infinity with `o_err` low.
- R9: `o_vld` equals `i_vld` delayed by the number of stage parameters set to 1, and the result follows with the same delay. With all five set to 0 the output is combinational. After reset `o_vld` is low.
- R10: `o_err` is low for every result not covered by R6 or R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| i_vld | input | 1 | Operands on `i_a`/`i_b` are valid this cycle |
| i_sub | input | 1 | 1: subtract `i_b` from `i_a`; 0: add |
| i_a | input | WEXP+WMAN | First operand |
| i_b | input | WEXP+WMAN | Second operand |
| o_vld | output | 1 | Result valid |
| o_res | output | WEXP+WMAN | Sum or difference |
| o_err | output | 1 | Overflow or infinity clash |

## Verification
An incorrect internal value in this block shows up at the ports on the very result that carries it, exactly the configured latency after the operands were applied. There is no state beyond the in-flight pipeline, so nothing lingers for later transactions.

A wrong swap decision or alignment shift corrupts the magnitude of a finite result. A bad sticky or guard bit moves a tie or near-tie result by one unit in the last place. A slip in the exponent arithmetic shows up at the range edges as a wrong flush, a missed min-normal lift, or a spurious infinity.

A miscounted stage register shows up as an `o_vld` pulse that is shifted in time relative to the gaps deliberately placed in the input valid stream.

// File: rtl/cfp_add_pkg.sv
package cfp_add_pkg;

    // Special-case outcome decided at decode and carried down the pipe.
    typedef enum logic [1:0] {
        SPC_NONE  = 2'd0,   // ordinary finite arithmetic
        SPC_INF   = 2'd1,   // result is an infinity
        SPC_CLASH = 2'd2    // opposite infinities met
    } spc_e;

endpackage

// File: rtl/cfp_stage_reg.sv
module cfp_stage_reg #(
    parameter int DW = 8,
    parameter int EN = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          d_vld,
    input  logic [DW-1:0] d,
    output logic          q_vld,
    output logic [DW-1:0] q
);

    generate
        if (EN != 0) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q_vld <= 1'b0;
                    q     <= '0;
                end else begin
                    q_vld <= d_vld;
                    q     <= d;
                end
            end
        end else begin : g_wire
            logic unused_clk;
            assign unused_clk = clk ^ rst_n;
            assign q_vld = d_vld;
            assign q     = d;
        end
    endgenerate

endmodule

// File: rtl/cfp_add_decode.sv
module cfp_add_decode
    import cfp_add_pkg::*;
#(
    parameter int WEXP = 6,
    parameter int WMAN = 18
) (
    input  logic [WEXP+WMAN-1:0] opa,
    input  logic [WEXP+WMAN-1:0] opb,
    input  logic                 sub,
    output logic                 lg_sign,
    output logic                 sm_sign,
    output logic [WEXP-1:0]      lg_exp,
    output logic [WEXP-1:0]      shift,
    output logic [WMAN-1:0]      lg_sig,
    output logic [WMAN-1:0]      sm_sig,
    output spc_e                 spc,
    output logic                 spc_sign
);

    localparam int W = WEXP + WMAN;

    logic            sa, sb, za, zb, ia, ib, swap;
    logic [WEXP-1:0] ea, eb, sm_exp;
    logic [W-2:0]    ka, kb;
    logic [WMAN-1:0] ga, gb;

    always_comb begin
        sa = opa[W-1];
        sb = opb[W-1] ^ sub;
        ea = opa[W-2 -: WEXP];
        eb = opb[W-2 -: WEXP];
        za = (ea == '0);
        zb = (eb == '0);
        ia = &ea;
        ib = &eb;
        // magnitude keys: a zero exponent hides any fraction bits
        ka = za ? '0 : opa[W-2:0];
        kb = zb ? '0 : opb[W-2:0];
        ga = za ? '0 : {1'b1, opa[WMAN-2:0]};
        gb = zb ? '0 : {1'b1, opb[WMAN-2:0]};
        swap = (kb > ka);

        lg_sign = swap ? sb : sa;
        sm_sign = swap ? sa : sb;
        lg_exp  = swap ? eb : ea;
        sm_exp  = swap ? ea : eb;
        lg_sig  = swap ? gb : ga;
        sm_sig  = swap ? ga : gb;
        shift   = lg_exp - sm_exp;

        spc      = SPC_NONE;
        spc_sign = 1'b0;
        if (ia || ib) begin
            if (ia && ib && (sa != sb)) begin
                spc = SPC_CLASH;
            end else begin
                spc      = SPC_INF;
                spc_sign = ia ? sa : sb;
            end
        end
    end

endmodule

// File: rtl/cfp_add_align.sv
module cfp_add_align #(
    parameter int WEXP = 6,
    parameter int WMAN = 18
) (
    input  logic [WMAN-1:0] lg_sig,
    input  logic [WMAN-1:0] sm_sig,
    input  logic [WEXP-1:0] shift,
    output logic [WMAN+2:0] lg_ext,
    output logic [WMAN+2:0] sm_aln
);

    localparam int XW  = WMAN + 3;          // significand plus guard, round, sticky
    localparam int SHW = $clog2(XW + 1);

    logic [SHW-1:0] dcl;
    logic [XW-1:0]  sm_ext, lost;

    always_comb begin
        if (int'(shift) >= XW) dcl = SHW'(XW);
        else                   dcl = SHW'(shift);
        sm_ext = {sm_sig, 3'b000};
        lost   = sm_ext & ~({XW{1'b1}} << dcl);
        sm_aln = (sm_ext >> dcl) | XW'(|lost);
        lg_ext = {lg_sig, 3'b000};
    end

endmodule

// File: rtl/cfp_add_normalize.sv
module cfp_add_normalize #(
    parameter int WEXP = 6,
    parameter int WMAN = 18,
    parameter int EW   = 13
) (
    input  logic                 eff_sub,
    input  logic                 lg_sign,
    input  logic [WEXP-1:0]      lg_exp,
    input  logic [WMAN+2:0]      lg_ext,
    input  logic [WMAN+2:0]      sm_aln,
    output logic                 n_sign,
    output logic signed [EW-1:0] n_exp,
    output logic [WMAN+2:0]      n_sig
);

    localparam int XW  = WMAN + 3;
    localparam int LZW = $clog2(XW + 1);

    logic [XW:0]          sum;
    logic [LZW-1:0]       lz;
    logic                 found;
    logic signed [EW-1:0] ex0;

    always_comb begin
        sum = eff_sub ? ({1'b0, lg_ext} - {1'b0, sm_aln})
                      : ({1'b0, lg_ext} + {1'b0, sm_aln});
        lz    = '0;
        found = 1'b0;
        for (int i = XW - 1; i >= 0; i--) begin
            if (!found) begin
                if (sum[i]) found = 1'b1;
                else        lz    = lz + LZW'(1);
            end
        end
        ex0    = EW'(lg_exp);
        n_sign = lg_sign;
        if (sum[XW]) begin
            n_sig = {sum[XW:2], sum[1] | sum[0]};
            n_exp = ex0 + EW'(1);
        end else begin
            n_sig = sum[XW-1:0] << lz;
            n_exp = ex0 - EW'(lz);
        end
    end

endmodule

// File: rtl/cfp_add_pack.sv
module cfp_add_pack
    import cfp_add_pkg::*;
#(
    parameter int WEXP = 6,
    parameter int WMAN = 18,
    parameter int EW   = 13
) (
    input  logic                 n_sign,
    input  logic signed [EW-1:0] n_exp,
    input  logic [WMAN+2:0]      n_sig,
    input  spc_e                 spc,
    input  logic                 spc_sign,
    output logic [WEXP+WMAN-1:0] res,
    output logic                 err
);

    localparam int EMAX = (1 << WEXP) - 1;

    logic [WMAN-1:0]      mant;
    logic [WMAN-2:0]      frac;
    logic                 up, cy, hid;
    logic signed [EW-1:0] ef;

    always_comb begin
        mant      = n_sig[WMAN+2:3];
        hid       = mant[WMAN-1];
        up        = n_sig[2] & (n_sig[1] | n_sig[0] | mant[0]);
        {cy, frac} = {1'b0, mant[WMAN-2:0]} + WMAN'(up);
        ef        = n_exp + EW'(cy);

        res = '0;
        err = 1'b0;
        unique case (spc)
            SPC_INF:   res = {spc_sign, {WEXP{1'b1}}, {(WMAN-1){1'b0}}};
            SPC_CLASH: err = 1'b1;
            default: begin
                if (!hid || n_exp < 0) begin
                    res = '0;
                end else if (n_exp == 0) begin
                    res = {n_sign, WEXP'(1), {(WMAN-1){1'b0}}};
                end else if (ef >= EW'(EMAX)) begin
                    res = {n_sign, {WEXP{1'b1}}, {(WMAN-1){1'b0}}};
                    err = 1'b1;
                end else begin
                    res = {n_sign, ef[WEXP-1:0], frac};
                end
            end
        endcase
    end

endmodule

// File: rtl/cfp_adder.sv
module cfp_adder
    import cfp_add_pkg::*;
#(
    parameter int WEXP    = 6,
    parameter int WMAN    = 18,
    parameter int STG_DEC = 0,
    parameter int STG_ALN = 0,
    parameter int STG_NRM = 0,
    parameter int STG_PCK = 0,
    parameter int STG_OUT = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 i_vld,
    input  logic                 i_sub,
    input  logic [WEXP+WMAN-1:0] i_a,
    input  logic [WEXP+WMAN-1:0] i_b,
    output logic                 o_vld,
    output logic [WEXP+WMAN-1:0] o_res,
    output logic                 o_err
);

    localparam int W   = WEXP + WMAN;
    localparam int XW  = WMAN + 3;
    localparam int EW  = WEXP + $clog2(WMAN + 4) + 2;
    localparam int LAT = STG_DEC + STG_ALN + STG_NRM + STG_PCK + STG_OUT;
    localparam int DW  = 2 + 2 * WEXP + 2 * WMAN + 3;
    localparam int AW  = 2 + WEXP + 2 * XW + 3;
    localparam int NW  = 1 + EW + XW + 3;
    localparam int PW  = W + 1;

    // ---- decode ----
    logic            d_lgs, d_sms, d_spcs;
    logic [WEXP-1:0] d_lge, d_shift;
    logic [WMAN-1:0] d_lgsig, d_smsig;
    spc_e            d_spc;

    cfp_add_decode #(.WEXP(WEXP), .WMAN(WMAN)) u_dec (
        .opa(i_a), .opb(i_b), .sub(i_sub),
        .lg_sign(d_lgs), .sm_sign(d_sms), .lg_exp(d_lge), .shift(d_shift),
        .lg_sig(d_lgsig), .sm_sig(d_smsig), .spc(d_spc), .spc_sign(d_spcs)
    );

    logic          x_vld;
    logic [DW-1:0] x_bus;
    cfp_stage_reg #(.DW(DW), .EN(STG_DEC)) u_r_dec (
        .clk(clk), .rst_n(rst_n), .d_vld(i_vld),
        .d({d_lgs, d_sms, d_lge, d_shift, d_lgsig, d_smsig, d_spc, d_spcs}),
        .q_vld(x_vld), .q(x_bus)
    );

    logic            x_lgs, x_sms, x_spcs;
    logic [WEXP-1:0] x_lge, x_shift;
    logic [WMAN-1:0] x_lgsig, x_smsig;
    logic [1:0]      x_spc;
    assign {x_lgs, x_sms, x_lge, x_shift, x_lgsig, x_smsig, x_spc, x_spcs} = x_bus;

    // ---- align ----
    logic [XW-1:0] a_lgext, a_smaln;
    cfp_add_align #(.WEXP(WEXP), .WMAN(WMAN)) u_aln (
        .lg_sig(x_lgsig), .sm_sig(x_smsig), .shift(x_shift),
        .lg_ext(a_lgext), .sm_aln(a_smaln)
    );

    logic          y_vld;
    logic [AW-1:0] y_bus;
    cfp_stage_reg #(.DW(AW), .EN(STG_ALN)) u_r_aln (
        .clk(clk), .rst_n(rst_n), .d_vld(x_vld),
        .d({x_lgs, x_lgs ^ x_sms, x_lge, a_lgext, a_smaln, x_spc, x_spcs}),
        .q_vld(y_vld), .q(y_bus)
    );

    logic            y_lgs, y_effsub, y_spcs;
    logic [WEXP-1:0] y_lge;
    logic [XW-1:0]   y_lgext, y_smaln;
    logic [1:0]      y_spc;
    assign {y_lgs, y_effsub, y_lge, y_lgext, y_smaln, y_spc, y_spcs} = y_bus;

    // ---- add and normalise ----
    logic                 n_sign;
    logic signed [EW-1:0] n_exp;
    logic [XW-1:0]        n_sig;
    cfp_add_normalize #(.WEXP(WEXP), .WMAN(WMAN), .EW(EW)) u_nrm (
        .eff_sub(y_effsub), .lg_sign(y_lgs), .lg_exp(y_lge),
        .lg_ext(y_lgext), .sm_aln(y_smaln),
        .n_sign(n_sign), .n_exp(n_exp), .n_sig(n_sig)
    );

    logic          z_vld;
    logic [NW-1:0] z_bus;
    cfp_stage_reg #(.DW(NW), .EN(STG_NRM)) u_r_nrm (
        .clk(clk), .rst_n(rst_n), .d_vld(y_vld),
        .d({n_sign, n_exp, n_sig, y_spc, y_spcs}),
        .q_vld(z_vld), .q(z_bus)
    );

    logic          z_sign, z_spcs;
    logic [EW-1:0] z_exp;
    logic [XW-1:0] z_sig;
    logic [1:0]    z_spc;
    assign {z_sign, z_exp, z_sig, z_spc, z_spcs} = z_bus;

    // ---- round and pack ----
    logic [W-1:0] p_res;
    logic         p_err;
    cfp_add_pack #(.WEXP(WEXP), .WMAN(WMAN), .EW(EW)) u_pck (
        .n_sign(z_sign), .n_exp(signed'(z_exp)), .n_sig(z_sig),
        .spc(spc_e'(z_spc)), .spc_sign(z_spcs),
        .res(p_res), .err(p_err)
    );

    logic          w_vld;
    logic [PW-1:0] w_bus;
    cfp_stage_reg #(.DW(PW), .EN(STG_PCK)) u_r_pck (
        .clk(clk), .rst_n(rst_n), .d_vld(z_vld), .d({p_res, p_err}),
        .q_vld(w_vld), .q(w_bus)
    );

    logic [PW-1:0] o_bus;
    cfp_stage_reg #(.DW(PW), .EN(STG_OUT)) u_r_out (
        .clk(clk), .rst_n(rst_n), .d_vld(w_vld), .d(w_bus),
        .q_vld(o_vld), .q(o_bus)
    );
    assign {o_res, o_err} = o_bus;

    // ---- assertions ----
    logic [2:0] since_rst;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              since_rst <= '0;
        else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
    end

    // R3
    sub_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (y_vld && y_effsub && y_spc == SPC_NONE) |-> (y_lgext >= y_smaln));

    // R4
    no_negzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (o_vld && o_res[W-2 -: WEXP] == '0) |-> (o_res == '0));

    // R8
    inf_frac_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (o_vld && (&o_res[W-2 -: WEXP])) |-> (o_res[WMAN-2:0] == '0));

    // R10
    err_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (o_vld && o_err) |-> ((&o_res[W-2 -: WEXP]) || o_res == '0));

    generate
        if (LAT > 0) begin : g_lat
            // R9
            lat_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (since_rst >= 3'(LAT)) |-> (o_vld == $past(i_vld, LAT)));
        end else begin : g_lat0
            // R9
            lat_comb_chk: assert property (@(posedge clk) disable iff (!rst_n)
                o_vld == i_vld);
        end
    endgenerate

endmodule

// File: tb/tb_cfp_adder.sv
`timescale 1ns/1ps
module tb_cfp_adder;

    localparam int WE  = 3;
    localparam int WM  = 3;
    localparam int W   = WE + WM;
    localparam int EM  = (1 << WE) - 1;
    localparam int HM  = 1 << (WM - 1);
    localparam int NV  = 8192;
    localparam int LAT = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         i_vld = 1'b0;
    logic         i_sub = 1'b0;
    logic [W-1:0] i_a = '0;
    logic [W-1:0] i_b = '0;
    logic         p_vld, p_err, c_vld, c_err;
    logic [W-1:0] p_res, c_res;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    cfp_adder #(.WEXP(WE), .WMAN(WM), .STG_DEC(1), .STG_ALN(1),
                .STG_NRM(0), .STG_PCK(1), .STG_OUT(1)) dut (
        .clk(clk), .rst_n(rst_n), .i_vld(i_vld), .i_sub(i_sub),
        .i_a(i_a), .i_b(i_b), .o_vld(p_vld), .o_res(p_res), .o_err(p_err));

    cfp_adder #(.WEXP(WE), .WMAN(WM), .STG_DEC(0), .STG_ALN(0),
                .STG_NRM(0), .STG_PCK(0), .STG_OUT(0)) dut_comb (
        .clk(clk), .rst_n(rst_n), .i_vld(i_vld), .i_sub(i_sub),
        .i_a(i_a), .i_b(i_b), .o_vld(c_vld), .o_res(c_res), .o_err(c_err));

    // Exact arithmetic model in units of the smallest fraction step.
    task automatic ref_add(input logic [W-1:0] a, input logic [W-1:0] b,
                           input logic sub, output logic [W-1:0] r,
                           output logic e, output int cat);
        logic sa, sb, ia, ib, sg;
        int ma, mb, s, m, ex, q, rem, half;
        sa = a[W-1];
        sb = b[W-1] ^ sub;
        ia = (a[W-2 -: WE] == WE'(EM));
        ib = (b[W-2 -: WE] == WE'(EM));
        e = 1'b0;
        r = '0;
        if (ia || ib) begin
            if (ia && ib && sa != sb) begin
                e = 1'b1; cat = 7;
            end else begin
                sg = ia ? sa : sb;
                r = {sg, WE'(EM), (WM-1)'(0)}; cat = 8;
            end
        end else begin
            ma = (a[W-2 -: WE] == 0) ? 0 : (HM + int'(a[WM-2:0])) << (int'(a[W-2 -: WE]) - 1);
            mb = (b[W-2 -: WE] == 0) ? 0 : (HM + int'(b[WM-2:0])) << (int'(b[W-2 -: WE]) - 1);
            s  = (sa ? -ma : ma) + (sb ? -mb : mb);
            sg = (s < 0);
            m  = sg ? -s : s;
            if (m == 0) begin
                cat = 4;
            end else if (m < HM / 2) begin
                cat = 5;
            end else if (m < HM) begin
                r = {sg, WE'(1), (WM-1)'(0)}; cat = 5;
            end else begin
                ex = 1;
                while (m >= ((2 * HM) << (ex - 1))) ex++;
                q   = m >> (ex - 1);
                rem = m - (q << (ex - 1));
                if (ex > 1) begin
                    half = 1 << (ex - 2);
                    if (rem > half || (rem == half && (q % 2) == 1)) q++;
                end
                if (q == 2 * HM) begin q = HM; ex++; end
                if (ex >= EM) begin
                    r = {sg, WE'(EM), (WM-1)'(0)}; e = 1'b1; cat = 6;
                end else begin
                    r = {sg, WE'(ex), (WM-1)'(q)}; cat = sub ? 3 : 2;
                end
            end
        end
    endtask

    function automatic string tag_of(input int cat);
        case (cat)
            3: return "R3";
            4: return "R4";
            5: return "R5";
            6: return "R6";
            7: return "R7";
            8: return "R8";
            default: return "R2";
        endcase
    endfunction

    task automatic check_vec(input int k, input logic vld, input logic [W-1:0] res,
                             input logic err, input string who);
        logic [12:0]  kv;
        logic         ve, ee;
        logic [W-1:0] re;
        int           cat;
        kv = 13'(k);
        ve = ((k % 7) != 3);
        checks++;
        if (vld !== ve) begin
            fails++;
            $display("FAIL R9 %s vec=%0d vld actual=%b expected=%b", who, k, vld, ve);
        end
        if (ve) begin
            ref_add(kv[5:0], kv[11:6], kv[12], re, ee, cat);
            checks++;
            if (res !== re) begin
                fails++;
                $display("FAIL %s %s vec=%0d res actual=%h expected=%h",
                         tag_of(cat), who, k, res, re);
            end
            checks++;
            if (err !== ee) begin
                fails++;
                $display("FAIL %s %s vec=%0d err actual=%b expected=%b",
                         (cat == 6 || cat == 7) ? tag_of(cat) : "R10", who, k, err, ee);
            end
        end
    endtask

    task automatic direct(input logic [W-1:0] a, input logic [W-1:0] b,
                          input logic [W-1:0] want, input string what);
        i_vld = 1'b1; i_sub = 1'b0; i_a = a; i_b = b;
        #1;
        checks++;
        if (c_res !== want || c_err !== 1'b0) begin
            fails++;
            $display("FAIL R1 %s actual=%h/%b expected=%h/0", what, c_res, c_err, want);
        end
    endtask

    initial begin
        logic [12:0] kv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        checks++;
        if (p_vld !== 1'b0 || c_vld !== 1'b0) begin
            fails++;
            $display("FAIL R9 reset vld actual=%b/%b expected=0/0", p_vld, c_vld);
        end
        for (int j = 0; j <= NV + LAT; j++) begin
            @(negedge clk);
            if (j >= 1 && j - 1 < NV)   check_vec(j - 1, c_vld, c_res, c_err, "comb");
            if (j >= LAT && j - LAT < NV) check_vec(j - LAT, p_vld, p_res, p_err, "pipe");
            if (j < NV) begin
                kv    = 13'(j);
                i_vld = ((j % 7) != 3);
                i_a   = kv[5:0];
                i_b   = kv[11:6];
                i_sub = kv[12];
            end else begin
                i_vld = 1'b0;
            end
        end
        // R1: field layout and bias (bias 3): 1.0 = 0_011_00
        @(negedge clk);
        direct(6'h0C, 6'h0C, 6'h10, "1.0+1.0");
        direct(6'h0E, 6'h04, 6'h0F, "1.5+0.25");
        direct(6'h0C, 6'h03, 6'h0C, "1.0+zero-with-fraction");
        i_vld = 1'b0;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule